// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block decides which interrupt a small 8-bit control unit services, and when it does so. Six sources feed it: an external pin, three timer/PWM channels, a serial interface and an ADC. Each request is latched as pending and filtered by an enable bit for its source. The block grants a request only when the core reports an instruction boundary. A boundary is the completion of an arithmetic or logic instruction, or the completion of a whole fuzzy rule. A grant is a one-cycle acknowledge together with a push request and a 5-bit vector address. On that push the core saves its arithmetic flags and program counter on its stack and then jumps.

The controller keeps one in-service bit per source, which allows nesting up to six levels deep. A running routine can be interrupted only by a source of strictly higher priority. A return pulse releases the most urgent active level, so priority falls back to the level of the preempted context. A global pending term shows that some enabled request is waiting. Actual grants also need two separate global masks to allow them: one for the main program and one for macros.

Top module: `nest_irq_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no stimulus, `ack_o`, `push_o`, `gip_o` and `isr_o` are all zero. Both global masks start disabled.
- R2: A one-cycle high on `irq_i[k]` sets a pending flag for source k. The flag stays set until source k is granted.
- R3: A grant appears as `ack_o` high in the cycle after a clock edge at which `alu_done_i` or `rule_done_i` was high. Without such a boundary there is never a grant.
- R4: Among eligible pending sources, the lowest index wins. The indices are: 0 external, 1 timer/PWM0, 2 timer/PWM1, 3 timer/PWM2, 4 serial, 5 ADC. `vec_o` is 3 + 3·index, so the vectors are 3, 6, 9, 12, 15 and 18.
- R5: `push_o` is high together with `ack_o` for one cycle. At the same time the granted pending flag is cleared and the granted bit of `isr_o` is set.
- R6: A source whose `src_en_i` bit is 0 is never granted and does not count toward `gip_o`. It stays pending and can be granted once it is enabled again.
- R7: While any `isr_o` bit is set, only a source with a lower index than every set bit can be granted. Sources of equal or lower priority wait.
- R8: A `reti_i` pulse clears the lowest-index set bit of `isr_o`. No grant is issued for a boundary that coincides with `reti_i`.
- R9: `gip_o` is high whenever some enabled source is pending. A grant additionally needs both the user mask and the macro mask to be enabled.
- R10: `user_ge_set_i`/`user_ge_clr_i` enable and disable the user mask, and `macro_ge_set_i`/`macro_ge_clr_i` do the same for the macro mask. When set and clear arrive together, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 6 | Request inputs, one per source |
| src_en_i | input | 6 | Per-source enable |
| alu_done_i | input | 1 | Arithmetic/logic instruction completed |
| rule_done_i | input | 1 | Fuzzy rule completed |
| reti_i | input | 1 | Return-from-interrupt pulse |
| user_ge_set_i | input | 1 | Enable user global mask |
| user_ge_clr_i | input | 1 | Disable user global mask |
| macro_ge_set_i | input | 1 | Enable macro global mask |
| macro_ge_clr_i | input | 1 | Disable macro global mask |
| ack_o | output | 1 | Grant pulse |
| push_o | output | 1 | Request to push flags and PC |
| vec_o | output | 5 | Vector address of the granted source |
| gip_o | output | 1 | Global pending: an enabled request waits |
| isr_o | output | 6 | In-service bits, one per source |

## Verification
The bench builds the block with its default parameters: six sources, a 5-bit vector, base 3 and stride 3. With these values all six vectors from 3 to 18 can be reached, and so can a full nesting chain. Predicted vectors are compared against each grant as it occurs. The scenarios cover strict-priority preemption, waiting at equal priority, sources disabled while pending, each global mask on its own, a set and a clear of a mask in the same cycle, and a return that coincides with a boundary.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum int unsigned {
    SRC_EXT   = 0,
    SRC_TMR0  = 1,
    SRC_TMR1  = 2,
    SRC_TMR2  = 3,
    SRC_SER   = 4,
    SRC_ADC   = 5
  } nic_src_e;

  localparam int unsigned NIC_DEF_NSRC   = 6;
  localparam int unsigned NIC_DEF_VEC_W  = 5;
  localparam int unsigned NIC_DEF_BASE   = 3;
  localparam int unsigned NIC_DEF_STRIDE = 3;
endpackage

// File: rtl/nic_pend.sv
module nic_pend #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q, pend_d;
  logic         upd;

  always_comb begin
    upd    = (|req_i) | (|clr_i);
    pend_d = (pend_q & ~clr_i) | req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/nic_arb.sv
module nic_arb #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] elig_i,
  input  logic [N-1:0] isr_i,
  output logic [N-1:0] win_o,
  output logic         any_o
);
  // index 0 is the most urgent source
  for (genvar i = 0; i < N; i++) begin : g_slot
    if (i == 0) begin : g_top
      assign win_o[i] = elig_i[i] & ~isr_i[i];
    end else begin : g_rest
      assign win_o[i] = elig_i[i] & ~(|elig_i[i-1:0]) & ~(|isr_i[i:0]);
    end
  end

  assign any_o = |win_o;
endmodule

// File: rtl/nic_nest.sv
module nic_nest #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         reti_i,
  output logic [N-1:0] isr_o
);
  logic [N-1:0] isr_q, isr_d;
  logic         upd;

  always_comb begin
    upd   = reti_i | (|set_i);
    isr_d = isr_q;
    if (reti_i) isr_d = isr_q & (isr_q - N'(1));
    isr_d = isr_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   isr_q <= '0;
    else if (upd) isr_q <= isr_d;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/nic_gmask.sv
module nic_gmask (
  input  logic clk,
  input  logic rst_n,
  input  logic u_set_i,
  input  logic u_clr_i,
  input  logic m_set_i,
  input  logic m_clr_i,
  output logic u_en_o,
  output logic m_en_o
);
  logic u_q, u_d, m_q, m_d, u_upd, m_upd;

  always_comb begin
    u_upd = u_set_i | u_clr_i;
    m_upd = m_set_i | m_clr_i;
    u_d   = ~u_clr_i;
    m_d   = ~m_clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_q <= 1'b0;
      m_q <= 1'b0;
    end else begin
      if (u_upd) u_q <= u_d;
      if (m_upd) m_q <= m_d;
    end
  end

  assign u_en_o = u_q;
  assign m_en_o = m_q;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int unsigned NSRC       = NIC_DEF_NSRC,
  parameter int unsigned VEC_W      = NIC_DEF_VEC_W,
  parameter int unsigned VEC_BASE   = NIC_DEF_BASE,
  parameter int unsigned VEC_STRIDE = NIC_DEF_STRIDE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_i,
  input  logic [NSRC-1:0]  src_en_i,
  input  logic             alu_done_i,
  input  logic             rule_done_i,
  input  logic             reti_i,
  input  logic             user_ge_set_i,
  input  logic             user_ge_clr_i,
  input  logic             macro_ge_set_i,
  input  logic             macro_ge_clr_i,
  output logic             ack_o,
  output logic             push_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             gip_o,
  output logic [NSRC-1:0]  isr_o
);
  localparam int unsigned SYNC_D = 2;

  logic [SYNC_D-1:0] rst_sync_q;
  logic              rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_D-2:0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[SYNC_D-1];

  logic [NSRC-1:0] pend, elig, win, grant_vec, isr;
  logic            win_any, user_ge, macro_ge, boundary, take;

  nic_pend #(.N(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_s_n), .req_i(irq_i), .clr_i(grant_vec), .pend_o(pend)
  );

  assign elig = pend & src_en_i;

  nic_arb #(.N(NSRC)) u_arb (
    .elig_i(elig), .isr_i(isr), .win_o(win), .any_o(win_any)
  );

  nic_gmask u_gmask (
    .clk(clk), .rst_n(rst_s_n),
    .u_set_i(user_ge_set_i), .u_clr_i(user_ge_clr_i),
    .m_set_i(macro_ge_set_i), .m_clr_i(macro_ge_clr_i),
    .u_en_o(user_ge), .m_en_o(macro_ge)
  );

  always_comb begin
    boundary  = alu_done_i | rule_done_i;
    take      = boundary & win_any & user_ge & macro_ge & ~reti_i;
    grant_vec = take ? win : '0;
  end

  nic_nest #(.N(NSRC)) u_nest (
    .clk(clk), .rst_n(rst_s_n), .set_i(grant_vec), .reti_i(reti_i), .isr_o(isr)
  );

  logic [VEC_W-1:0] vec_d, vec_q;
  logic             ack_q, push_q;

  always_comb begin
    vec_d = vec_q;
    for (int i = 0; i < int'(NSRC); i++) begin
      if (grant_vec[i]) vec_d = VEC_W'(VEC_BASE + i * VEC_STRIDE);
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ack_q  <= 1'b0;
      push_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      ack_q  <= take;
      push_q <= take;
      if (take) vec_q <= vec_d;
    end
  end

  assign ack_o  = ack_q;
  assign push_o = push_q;
  assign vec_o  = vec_q;
  assign gip_o  = |elig;
  assign isr_o  = isr;
endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
  parameter int unsigned N     = 6,
  parameter int unsigned VEC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alu_done_i,
  input logic             rule_done_i,
  input logic             reti_i,
  input logic             ack_o,
  input logic             push_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             gip_o,
  input logic [N-1:0]     isr_o,
  input logic             user_ge,
  input logic             macro_ge
);
  p_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(alu_done_i || rule_done_i));

  p_push_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (push_o && $countones(isr_o) == $countones($past(isr_o)) + 1));

  p_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && $past(isr_o) != '0) |->
      ((isr_o & ~$past(isr_o)) < ($past(isr_o) & (~$past(isr_o) + N'(1)))));

  p_reti_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && isr_o != '0) |=>
      (!ack_o && $countones(isr_o) + 1 == $countones($past(isr_o))));

  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(gip_o && user_ge && macro_ge));
endmodule

bind nest_irq_ctrl nic_chk #(.N(NSRC), .VEC_W(VEC_W)) u_nic_chk (
  .clk(clk), .rst_n(rst_n), .alu_done_i(alu_done_i), .rule_done_i(rule_done_i),
  .reti_i(reti_i), .ack_o(ack_o), .push_o(push_o), .vec_o(vec_o),
  .gip_o(gip_o), .isr_o(isr_o), .user_ge(user_ge), .macro_ge(macro_ge)
);

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] irq, src_en, isr;
  logic       alu_done, rule_done, reti, ug_set, ug_clr, mg_set, mg_clr;
  logic       ack, push, gip;
  logic [4:0] vec;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  nest_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .src_en_i(src_en),
    .alu_done_i(alu_done), .rule_done_i(rule_done), .reti_i(reti),
    .user_ge_set_i(ug_set), .user_ge_clr_i(ug_clr),
    .macro_ge_set_i(mg_set), .macro_ge_clr_i(mg_clr),
    .ack_o(ack), .push_o(push), .vec_o(vec), .gip_o(gip), .isr_o(isr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares each grant against the scoreboard queue
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (ack === 1'b1) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected grant", int'(vec), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(vec == 5'(e), "R4 vector", int'(vec), e);
          chk(push === 1'b1, "R5 push with ack", int'(push), 1);
        end
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse_irq(input logic [5:0] m);
    @(negedge clk); irq = m;
    @(negedge clk); irq = '0;
  endtask

  task automatic bnd(input bit rule);
    @(negedge clk); if (rule) rule_done = 1'b1; else alu_done = 1'b1;
    @(negedge clk); rule_done = 1'b0; alu_done = 1'b0;
  endtask

  task automatic expect_grant(input int v, input bit rule, input string req);
    exp_q.push_back(v);
    bnd(rule);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic expect_none(input string req);
    bnd(1'b0);
    chk(ack === 1'b0, req, int'(ack), 0);
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic gm(input bit us, input bit uc, input bit ms, input bit mc);
    @(negedge clk); ug_set = us; ug_clr = uc; mg_set = ms; mg_clr = mc;
    @(negedge clk); ug_set = 0; ug_clr = 0; mg_set = 0; mg_clr = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq = '0; src_en = '0; alu_done = 0; rule_done = 0; reti = 0;
    ug_set = 0; ug_clr = 0; mg_set = 0; mg_clr = 0;
    repeat (3) tick();
    chk(ack === 1'b0 && push === 1'b0, "R1 reset ack/push", int'(ack), 0);
    chk(isr === 6'b0 && gip === 1'b0, "R1 reset isr/gip", int'(isr), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    // masks start disabled: enabled pending request must not be granted
    src_en = 6'b111111;
    pulse_irq(6'b000001);
    expect_none("R1 masks disabled after reset");
    gm(1, 0, 1, 0);
    expect_grant(3, 0, "R10 masks enabled by set pulses");
    do_reti();
    chk(isr === 6'b0, "R8 reti empties isr", int'(isr), 0);

    // R2: pulse held as pending, no boundary no grant
    pulse_irq(6'b100000);
    repeat (3) tick();
    chk(gip === 1'b1, "R2 pending kept / R9 gip", int'(gip), 1);
    chk(ack === 1'b0, "R3 no grant without boundary", int'(ack), 0);
    expect_grant(18, 0, "R3 ADC grant at boundary");
    chk(isr === 6'b100000, "R5 isr bit set", int'(isr), 32);
    chk(gip === 1'b0, "R5 pending cleared", int'(gip), 0);
    do_reti();

    // R4/R7: priority and nesting
    pulse_irq(6'b010110);
    expect_grant(6, 0, "R4 highest of three");
    chk(isr === 6'b000010, "R5 isr tmr0", int'(isr), 2);
    expect_none("R7 lower waits");
    chk(isr === 6'b000010, "R7 isr unchanged", int'(isr), 2);
    pulse_irq(6'b000001);
    expect_grant(3, 1, "R7 preempt by external on rule end");
    chk(isr === 6'b000011, "R7 nested isr", int'(isr), 3);
    do_reti();
    chk(isr === 6'b000010, "R8 reti pops top level", int'(isr), 2);
    do_reti();
    chk(isr === 6'b000000, "R8 second reti", int'(isr), 0);
    expect_grant(9, 0, "R4 tmr1 next");
    do_reti();
    expect_grant(15, 0, "R4 serial next");
    pulse_irq(6'b010000);
    expect_none("R7 equal priority waits");
    do_reti();
    expect_grant(15, 0, "R7 equal granted after reti");
    do_reti();

    // R6: per-source enable
    src_en = 6'b110111;
    pulse_irq(6'b001000);
    tick();
    chk(gip === 1'b0, "R6 disabled not in gip", int'(gip), 0);
    expect_none("R6 disabled not granted");
    src_en = 6'b111111;
    tick();
    chk(gip === 1'b1, "R6 still pending", int'(gip), 1);
    expect_grant(12, 0, "R6 granted once enabled");
    do_reti();

    // R9/R10: global masks
    gm(0, 1, 0, 0);
    pulse_irq(6'b000001);
    chk(gip === 1'b1, "R9 gip despite mask", int'(gip), 1);
    expect_none("R9 user mask blocks");
    gm(1, 0, 0, 1);
    expect_none("R9 macro mask blocks");
    gm(0, 0, 1, 0);
    gm(1, 1, 0, 0);
    expect_none("R10 clear wins over set");
    gm(1, 0, 0, 0);
    expect_grant(3, 1, "R9 both masks allow");
    do_reti();

    // R8: boundary coinciding with reti
    pulse_irq(6'b010000);
    @(negedge clk); alu_done = 1'b1; reti = 1'b1;
    @(negedge clk); alu_done = 1'b0; reti = 1'b0;
    chk(ack === 1'b0, "R8 no grant with reti", int'(ack), 0);
    expect_grant(15, 0, "R8 grant after reti cycle");
    do_reti();

    repeat (3) tick();
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule